// File: doc/BRIEF.md
# I2C Serial Clock Rate Generator

This block turns the system oscillator into the bit timing for a byte-oriented I2C controller. Each bit period has a low half followed by a high half. The block gives a one-cycle pulse when SCL should go high and another when it should go low. The falling pulse also serves as the bit-rate tick.

A 3-bit rate code picks the period. Codes 0 to 6 pick fixed oscillator divisors, and these divisors do not rise or fall in order. Code 7 takes its timing from the overflow pulses of an external 8-bit auto-reload timer. A core-speed input picks between the standard divisor set and the fast set, which is half as large.

A hold input freezes the phase counter. This models SCL being held low by another device. When the controller works as a slave, the block stays quiet and ignores the rate code.

The block has no data stream, so it uses no valid/ready interface. All of its pins are plain control and status lines.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: With `fast_core`=0, rate codes 0,1,2,3,4,5,6 give bit periods of 256, 224, 192, 160, 960, 120 and 60 clocks. Each period is split into a low half and a high half of equal length.
- R2: With `fast_core`=1, the same codes give exactly half the R1 periods: 128, 112, 96, 80, 480, 60 and 30 clocks.
- R3: Rate code 7 counts `timer_ovf` pulses instead of clocks. SCL changes phase after every 4 counted pulses, so one bit lasts 8 pulses. `fast_core` makes no difference to this count.
- R4: `scl_high` is 0 in the low half and 1 in the high half. `scl_rise` pulses for one cycle on entering the high half. `scl_fall` pulses for one cycle on entering the low half, and this pulse is the bit tick. The two pulses never occur together.
- R5: While `hold` is 1, the count does not advance and no pulse is produced. The remaining time of the current phase is kept.
- R6: The block restarts in the low phase with an empty count in any of these cases: `enable` is 0, the rate code changes, or `fast_core` changes. After a restart, the first `scl_rise` pulse appears on the edge that completes half a period of counted cycles.
- R7: While `slave` is 1, no pulse is produced, `scl_high` stays 0, and changes to the rate code have no effect.
- R8: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enabled |
| slave | input | 1 | Controller works as a slave |
| fast_core | input | 1 | 1 selects the halved divisor set |
| rate_code | input | 3 | Bit-rate selection |
| timer_ovf | input | 1 | One-cycle overflow pulse from the external reload timer |
| hold | input | 1 | Freeze the count (SCL held low externally) |
| scl_high | output | 1 | Current SCL phase, 1 for the high half |
| scl_rise | output | 1 | One-cycle pulse on entering the high half |
| scl_fall | output | 1 | One-cycle pulse on entering the low half (bit tick) |

## Verification
All three outputs are registered. A phase change therefore becomes visible right after the clock edge on which the count of cycles (or overflow pulses) since the last change reaches half a period. A restart or a slave cycle clears the outputs at the next edge.

The driver task applies the inputs for each edge half a cycle early. For every edge it computes the expected pulse pair and phase from the requirements, and it queues them tagged with that edge's number. The monitor samples at the following falling clock edge and pops the entry whose tag matches the cycle counter. In this way every expected change is compared on exactly the cycle in which it is due, and cycles that should be quiet are checked too.

// File: rtl/i2c_rate_pkg.sv
package i2c_rate_pkg;
  localparam int CODE_W = 3;
  localparam int HALF_W = 9;
  localparam logic [CODE_W-1:0] CODE_EXT = 3'd7;

  // half of the standard-core bit period, in oscillator clocks
  function automatic logic [HALF_W-1:0] std_half(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    std_half = 9'd128;
      3'd1:    std_half = 9'd112;
      3'd2:    std_half = 9'd96;
      3'd3:    std_half = 9'd80;
      3'd4:    std_half = 9'd480;
      3'd5:    std_half = 9'd60;
      3'd6:    std_half = 9'd30;
      default: std_half = 9'd0;
    endcase
  endfunction
endpackage

// File: rtl/rate_decode.sv
module rate_decode
  import i2c_rate_pkg::*;
#(
  parameter int W = HALF_W,
  parameter int OVF_HALF = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic              fast,
  output logic [W-1:0]      term,
  output logic              ext_src
);
  logic [W-1:0] half_clk;

  always_comb begin
    ext_src  = (code == CODE_EXT);
    half_clk = W'(std_half(code)) >> fast;
    term     = ext_src ? W'(OVF_HALF - 1) : half_clk - W'(1);
  end
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic         adv,
  input  logic [W-1:0] term,
  output logic         wrap
);
  logic [W-1:0] cnt_q;

  assign wrap = !restart && adv && (cnt_q == term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (wrap)     cnt_q <= '0;
    else if (adv)      cnt_q <= cnt_q + W'(1);
  end

  // R5: no advance means the count keeps its value
  a_r5_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && !adv) |=> $stable(cnt_q));
  // R6: a restart empties the count
  a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/phase_gen.sv
module phase_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic wrap,
  output logic high,
  output logic rise,
  output logic fall
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      high <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else if (restart) begin
      high <= 1'b0;
      rise <= 1'b0;
      fall <= 1'b0;
    end else begin
      rise <= wrap && !high;
      fall <= wrap && high;
      if (wrap) high <= !high;
    end
  end

  // R4: pulses are exclusive and agree with the phase they open
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise, fall}));
  a_r4_rise_high: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> high);
  a_r4_fall_low: assert property (@(posedge clk) disable iff (!rst_n)
    fall |-> !high);
  // R6: a restart returns to the low phase
  a_r6_restart_low: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!high && !rise && !fall));
endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen
  import i2c_rate_pkg::*;
#(
  parameter int OVF_PER_BIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              slave,
  input  logic              fast_core,
  input  logic [CODE_W-1:0] rate_code,
  input  logic              timer_ovf,
  input  logic              hold,
  output logic              scl_high,
  output logic              scl_rise,
  output logic              scl_fall
);
  localparam int OVF_HALF = OVF_PER_BIT / 2;

  logic [CODE_W:0]     sel_q;
  logic [HALF_W-1:0]   term;
  logic                ext_src;
  logic                run, restart, adv, wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= {fast_core, rate_code};
  end

  assign run     = enable && !slave;
  assign restart = !run || (sel_q != {fast_core, rate_code});
  assign adv     = !hold && (!ext_src || timer_ovf);

  rate_decode #(.W(HALF_W), .OVF_HALF(OVF_HALF)) u_dec (
    .code(rate_code), .fast(fast_core), .term(term), .ext_src(ext_src)
  );

  phase_counter #(.W(HALF_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .adv(adv),
    .term(term), .wrap(wrap)
  );

  phase_gen u_ph (
    .clk(clk), .rst_n(rst_n), .restart(restart), .wrap(wrap),
    .high(scl_high), .rise(scl_rise), .fall(scl_fall)
  );

  // R7: a slave cycle produces no phase change at the next edge
  a_r7_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    slave |=> (!scl_rise && !scl_fall && !scl_high));
  // R5: a held cycle changes nothing
  a_r5_hold_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && run) |=> (!scl_rise && !scl_fall));
endmodule

// File: tb/i2c_scl_rate_gen_tb.sv
module i2c_scl_rate_gen_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    int   cyc;
    logic rise;
    logic fall;
    logic high;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0, slave = 1'b0, fast_core = 1'b0, timer_ovf = 1'b0, hold = 1'b0;
  logic [2:0] rate_code = 3'd0;
  logic scl_high, scl_rise, scl_fall;

  int cyc = 0;
  int vectors = 0;
  int misses = 0;
  bit done = 0;
  string cur_req = "R8";
  exp_t q[$];

  int   m_n = 0;
  logic m_high = 1'b0;
  logic [3:0] m_sel = 4'd0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_scl_rate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .slave(slave),
    .fast_core(fast_core), .rate_code(rate_code), .timer_ovf(timer_ovf),
    .hold(hold), .scl_high(scl_high), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  // standard-core half periods from R1
  function automatic int half_of(input logic [2:0] c, input logic f);
    int h;
    case (c)
      3'd0: h = 128; 3'd1: h = 112; 3'd2: h = 96; 3'd3: h = 80;
      3'd4: h = 480; 3'd5: h = 60;  3'd6: h = 30; default: h = 8;
    endcase
    if (c == 3'd7) return 4;
    return f ? h / 2 : h;
  endfunction

  task automatic step(input logic en, input logic slv, input logic fst,
                      input logic [2:0] code, input logic hld, input logic ovf);
    exp_t it;
    int   half;
    logic rs;
    @(negedge clk);
    enable = en; slave = slv; fast_core = fst; rate_code = code;
    hold = hld; timer_ovf = ovf;
    half = half_of(code, fst);
    rs = !(en && !slv) || ({fst, code} != m_sel);
    m_sel = {fst, code};
    it.rise = 1'b0; it.fall = 1'b0;
    if (rs) begin
      m_n = 0; m_high = 1'b0;
    end else if (!hld && (code != 3'd7 || ovf)) begin
      if (m_n == half - 1) begin
        m_n = 0; m_high = !m_high;
        it.rise = m_high; it.fall = !m_high;
      end else m_n++;
    end
    it.cyc = cyc + 1; it.high = m_high;
    q.push_back(it);
  endtask

  task automatic run_n(input int n, input logic en, input logic slv, input logic fst,
                       input logic [2:0] code, input logic hld);
    for (int i = 0; i < n; i++)
      step(en, slv, fst, code, hld, (code == 3'd7) && (i % 5 == 4));
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // monitor: pop the entry due this cycle and compare
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t it;
      it = q.pop_front();
      if (it.rise || it.fall || scl_rise || scl_fall || it.high != scl_high) begin
        check(cur_req, "scl_rise", int'(scl_rise), int'(it.rise));
        check(cur_req, "scl_fall", int'(scl_fall), int'(it.fall));
        check(cur_req, "scl_high", int'(scl_high), int'(it.high));
      end
      if (scl_rise && scl_fall) check("R4", "both pulses", 1, 0);
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      misses++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8", "scl_high in reset", int'(scl_high), 0);
    check("R8", "scl_rise in reset", int'(scl_rise), 0);
    check("R8", "scl_fall in reset", int'(scl_fall), 0);
    rst_n = 1'b1;
    run_n(3, 0, 0, 0, 3'd0, 0);
    check("R8", "scl_high after reset", int'(scl_high), 0);

    cur_req = "R1";
    for (int c = 0; c < 7; c++) begin
      run_n(2, 0, 0, 0, 3'(c), 0);
      run_n(4 * half_of(3'(c), 0) + 3, 1, 0, 0, 3'(c), 0);
    end

    cur_req = "R2";
    for (int c = 0; c < 7; c++) begin
      run_n(2, 0, 0, 1, 3'(c), 0);
      run_n(4 * half_of(3'(c), 1) + 3, 1, 0, 1, 3'(c), 0);
    end

    cur_req = "R3";
    run_n(2, 0, 0, 0, 3'd7, 0);
    run_n(130, 1, 0, 0, 3'd7, 0);
    run_n(130, 1, 0, 1, 3'd7, 0);

    cur_req = "R5";
    run_n(2, 0, 0, 1, 3'd6, 0);
    run_n(20, 1, 0, 1, 3'd6, 0);
    run_n(9, 1, 0, 1, 3'd6, 1);
    run_n(40, 1, 0, 1, 3'd6, 0);
    run_n(60, 1, 0, 0, 3'd7, 1);
    run_n(60, 1, 0, 0, 3'd7, 0);

    cur_req = "R6";
    run_n(50, 1, 0, 1, 3'd5, 0);
    run_n(70, 1, 0, 1, 3'd6, 0);
    run_n(25, 1, 0, 0, 3'd6, 0);
    run_n(2, 0, 0, 0, 3'd6, 0);
    run_n(70, 1, 0, 0, 3'd6, 0);

    cur_req = "R7";
    for (int c = 0; c < 8; c++) run_n(40, 1, 1, 1, 3'(c), 0);
    check("R7", "scl_high as slave", int'(scl_high), 0);
    run_n(40, 1, 0, 1, 3'd6, 0);

    cur_req = "R4";
    run_n(70, 1, 0, 1, 3'd6, 0);

    repeat (2) @(negedge clk);
    check("R4", "queue drained", q.size(), 0);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule